// File: doc/BRIEF.md
# Second-Level Zero Suppressor with Fine-Time Extraction

This block shrinks a captured hit record before it is stored or sent. A record arrives as a 16-bit coarse timestamp and two consecutive sample memories of 16 cells each, every cell holding a 4-bit level. The memories are searched as one sequence of 32 cells: the first memory's cells 0 to 15, then the second memory's cells 16 to 31. The position of the first non-zero cell becomes the fine time.

From that position a window of 16 consecutive cells is kept and everything else is dropped. A window that runs past the last cell is padded with zero cells. When the first non-zero cell lies in the second memory, the hit belongs to the next coarse period, so the coarse time goes out incremented by one. The reduced record is 84 bits wide, against 128 bits of sample data plus the timestamp at the input. A record with no non-zero cell produces nothing.

The block accepts one record per clock with no stalls. Every result appears exactly two clocks after its input.

Top module: `szs_reducer`

## Requirements
- R1: A record presented with `in_valid` high and at least one non-zero cell raises `out_valid` exactly two clock edges later. A cycle with `in_valid` low, or with all 32 cells zero, leaves `out_valid` low two edges later.
- R2: Cell k (k = 0..31) is `in_cells[4k+3:4k]`. Cells 0..15 form the first memory and cells 16..31 the second, and they are searched in that order. The fine-time field is the low 4 bits of the index of the lowest-numbered non-zero cell.
- R3: The coarse field equals `in_coarse` when the first non-zero cell is in the first memory. It equals `in_coarse + 1` modulo 2^16 when that cell is in the second memory.
- R4: Window cell j (j = 0..15), at record bits [4j+3:4j], equals input cell idx+j, where idx is the 0..31 index of R2. It is zero when idx+j > 31. Window cell 0 is therefore never zero.
- R5: The output record layout is coarse time in bits [83:68], fine time in [67:64] and the window in [63:0].
- R6: While `rst_n` is low and after its release, `out_valid` stays low until a qualifying record has passed through the two stages.
- R7: Records on consecutive clocks are each processed independently and emerge on consecutive clocks, with no lost or merged results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input record present this cycle |
| in_coarse | input | 16 | Coarse timestamp of the record |
| in_cells | input | 128 | 32 cells of 4 bits, cell k at [4k+3:4k] |
| out_valid | output | 1 | Reduced record present |
| out_record | output | 84 | {coarse, fine, window} reduced record |

## Verification
On every cycle the assertions check the two-cycle emit and suppress timing, that the first window cell is non-zero, and that the coarse field is the input timestamp or that value plus one. They also check that the stage-one index points at a non-zero cell. Which of the two coarse values is correct, the exact window contents, zero padding near cell 31 and timestamp wrap from 16'hFFFF can only be shown by the bench. It does this through directed edge positions and a seeded random stream whose results are compared with an independent reference function.

// File: rtl/szs_pkg.sv
package szs_pkg;
  localparam int unsigned SZS_CELLS = 16;
  localparam int unsigned SZS_NMEM  = 2;
  localparam int unsigned SZS_LVL_W = 4;
  localparam int unsigned SZS_CT_W  = 16;
  localparam int unsigned SZS_WIN   = 16;
endpackage

// File: rtl/szs_first_find.sv
module szs_first_find #(
  parameter int unsigned TOTAL = 32,
  parameter int unsigned LVL_W = 4,
  parameter int unsigned IDX_W = $clog2(TOTAL)
) (
  input  logic [TOTAL*LVL_W-1:0] cells,
  output logic                   found,
  output logic [IDX_W-1:0]       idx
);
  logic [TOTAL-1:0] nz;

  // One occupancy flag per cell
  for (genvar g = 0; g < TOTAL; g++) begin : g_nz
    assign nz[g] = |cells[g*LVL_W +: LVL_W];
  end

  assign found = |nz;

  // Lowest index wins: scan downward so the last match is the lowest
  always_comb begin
    idx = '0;
    for (int i = TOTAL - 1; i >= 0; i--) begin
      if (nz[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/szs_window_shift.sv
module szs_window_shift #(
  parameter int unsigned TOTAL = 32,
  parameter int unsigned LVL_W = 4,
  parameter int unsigned WIN   = 16,
  parameter int unsigned IDX_W = $clog2(TOTAL)
) (
  input  logic [TOTAL*LVL_W-1:0] cells,
  input  logic [IDX_W-1:0]       shift,
  output logic [WIN*LVL_W-1:0]   window
);
  localparam int unsigned IN_W  = TOTAL * LVL_W;
  localparam int unsigned WIN_W = WIN * LVL_W;
  localparam int unsigned EXT_W = IN_W + WIN_W;

  logic [EXT_W-1:0] stg [0:IDX_W];

  // Zero cells above the top supply the padding past the last cell
  assign stg[0] = {{WIN_W{1'b0}}, cells};

  // Logarithmic barrel: stage k moves by 2^k whole cells
  for (genvar k = 0; k < IDX_W; k++) begin : g_stage
    localparam int unsigned AMT = (1 << k) * LVL_W;
    assign stg[k+1] = shift[k] ? (stg[k] >> AMT) : stg[k];
  end

  assign window = stg[IDX_W][WIN_W-1:0];
endmodule

// File: rtl/szs_coarse_adj.sv
module szs_coarse_adj #(
  parameter int unsigned CT_W  = 16,
  parameter int unsigned SEL_W = 1
) (
  input  logic [CT_W-1:0]  coarse_i,
  input  logic [SEL_W-1:0] mem_sel,
  output logic [CT_W-1:0]  coarse_o
);
  // Each later memory spans one further coarse period
  assign coarse_o = coarse_i + CT_W'(mem_sel);
endmodule

// File: rtl/szs_reducer.sv
module szs_reducer
  import szs_pkg::*;
#(
  parameter int unsigned CELLS = SZS_CELLS,
  parameter int unsigned NMEM  = SZS_NMEM,
  parameter int unsigned LVL_W = SZS_LVL_W,
  parameter int unsigned CT_W  = SZS_CT_W,
  parameter int unsigned WIN   = SZS_WIN
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         in_valid,
  input  logic [CT_W-1:0]                              in_coarse,
  input  logic [CELLS*NMEM*LVL_W-1:0]                  in_cells,
  output logic                                         out_valid,
  output logic [CT_W+$clog2(CELLS)+WIN*LVL_W-1:0]      out_record
);
  localparam int unsigned TOTAL  = CELLS * NMEM;
  localparam int unsigned IDX_W  = $clog2(TOTAL);
  localparam int unsigned FINE_W = $clog2(CELLS);
  localparam int unsigned SEL_W  = IDX_W - FINE_W;
  localparam int unsigned IN_W   = TOTAL * LVL_W;
  localparam int unsigned WIN_W  = WIN * LVL_W;
  localparam int unsigned REC_W  = CT_W + FINE_W + WIN_W;

  // Stage 1: search
  logic             hit_found;
  logic [IDX_W-1:0] hit_idx;

  szs_first_find #(.TOTAL(TOTAL), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_find (
    .cells (in_cells),
    .found (hit_found),
    .idx   (hit_idx)
  );

  logic             s1_valid_d, s1_valid_q;
  logic             s1_load;
  logic [CT_W-1:0]  s1_coarse_q;
  logic [IN_W-1:0]  s1_cells_q;
  logic [IDX_W-1:0] s1_idx_q;

  always_comb begin
    s1_valid_d = in_valid & hit_found;
    s1_load    = s1_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid_q <= 1'b0;
    else        s1_valid_q <= s1_valid_d;
  end

  always_ff @(posedge clk) begin
    if (s1_load) begin
      s1_coarse_q <= in_coarse;
      s1_cells_q  <= in_cells;
      s1_idx_q    <= hit_idx;
    end
  end

  // Stage 2: window and timestamp adjust
  logic [WIN_W-1:0] win_cells;
  logic [CT_W-1:0]  coarse_adj;

  szs_window_shift #(.TOTAL(TOTAL), .LVL_W(LVL_W), .WIN(WIN), .IDX_W(IDX_W)) u_win (
    .cells  (s1_cells_q),
    .shift  (s1_idx_q),
    .window (win_cells)
  );

  szs_coarse_adj #(.CT_W(CT_W), .SEL_W(SEL_W)) u_cadj (
    .coarse_i (s1_coarse_q),
    .mem_sel  (s1_idx_q[IDX_W-1:FINE_W]),
    .coarse_o (coarse_adj)
  );

  logic             out_valid_q;
  logic [REC_W-1:0] rec_d, rec_q;

  always_comb begin
    rec_d = {coarse_adj, s1_idx_q[FINE_W-1:0], win_cells};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid_q <= 1'b0;
    else        out_valid_q <= s1_valid_q;
  end

  always_ff @(posedge clk) begin
    if (s1_valid_q) rec_q <= rec_d;
  end

  assign out_valid  = out_valid_q;
  assign out_record = rec_q;

  // R1
  hit_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_cells != '0)) |-> ##2 out_valid);

  // R1
  empty_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && (in_cells != '0)) |-> ##2 !out_valid);

  // R2
  fine_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid_q |-> (s1_cells_q[s1_idx_q*LVL_W +: LVL_W] != '0));

  // R4
  lead_cell_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_record[LVL_W-1:0] != '0));

  // R3
  coarse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_record[REC_W-1 -: CT_W] == $past(in_coarse, 2)) ||
                   (out_record[REC_W-1 -: CT_W] == $past(in_coarse, 2) + CT_W'(1))));
endmodule

// File: tb/tb_szs_reducer.sv
module tb_szs_reducer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [15:0]  in_coarse;
  logic [127:0] in_cells;
  logic         out_valid;
  logic [83:0]  out_record;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  szs_reducer dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .in_coarse (in_coarse), .in_cells (in_cells),
    .out_valid (out_valid), .out_record (out_record)
  );

  // Reference: {found, record}; record layout per R5
  function automatic logic [84:0] ref_model(input logic [127:0] c, input logic [15:0] ct);
    int first = -1;
    logic [63:0] w = '0;
    logic [15:0] co;
    for (int i = 31; i >= 0; i--) if (c[i*4 +: 4] != 4'h0) first = i;
    if (first < 0) return '0;
    for (int j = 0; j < 16; j++) if (first + j <= 31) w[j*4 +: 4] = c[(first+j)*4 +: 4];
    co = (first >= 16) ? ct + 16'd1 : ct;
    return {1'b1, co, 4'(first % 16), w};
  endfunction

  logic [84:0] exp1, exp2;
  logic        prev_v;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp1 <= '0; exp2 <= '0;
    end else begin
      exp1 <= in_valid ? ref_model(in_cells, in_coarse) : '0;
      exp2 <= exp1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [83:0] act, input logic [83:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid == exp2[84], prev_v ? "R7 valid" : "R1 valid",
          84'(out_valid), 84'(exp2[84]));
      if (exp2[84] && out_valid) begin
        // R5 field positions
        chk(out_record[83:68] == exp2[83:68], "R3 coarse", 84'(out_record[83:68]), 84'(exp2[83:68]));
        chk(out_record[67:64] == exp2[67:64], "R2 fine",   84'(out_record[67:64]), 84'(exp2[67:64]));
        chk(out_record[63:0]  == exp2[63:0],  "R4 window", 84'(out_record[63:0]),  84'(exp2[63:0]));
      end
      prev_v = exp2[84];
    end
  end

  task automatic drive(input bit v, input logic [15:0] ct, input logic [127:0] c);
    @(negedge clk);
    in_valid = v; in_coarse = ct; in_cells = c;
  endtask

  function automatic logic [127:0] rand_cells();
    logic [127:0] c = '0;
    int start = $urandom_range(0, 31);
    for (int k = start; k < 32; k++) c[k*4 +: 4] = 4'($urandom_range(0, 15));
    c[start*4 +: 4] = 4'($urandom_range(1, 15));
    return c;
  endfunction

  initial begin
    void'($urandom(32'h5A17));
    prev_v = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_coarse = '0; in_cells = '0;
    repeat (3) @(negedge clk);
    // R6: nothing out while held in reset
    chk(out_valid == 1'b0, "R6 reset", 84'(out_valid), 84'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 after release", 84'(out_valid), 84'(0));

    // Directed corners
    drive(1, 16'h1234, 128'h0);                       // R1 empty record
    drive(1, 16'h0001, 128'h7);                       // cell 0
    drive(1, 16'h0002, 128'h9 << (15*4));             // cell 15, last in first memory
    drive(1, 16'h0003, 128'hA << (16*4));             // cell 16, first in second memory
    drive(1, 16'hFFFF, 128'h5 << (20*4));             // R3 wrap
    drive(1, 16'h0004, 128'h3 << (31*4));             // R4 cell 31, all padding
    drive(1, 16'h0005, {4'hF, 120'h0, 4'h1});         // cells 0 and 31
    drive(0, 16'h0006, 128'h1);                       // invalid ignored
    drive(1, 16'h0007, {32{4'hC}});                   // full record

    // Random back-to-back stream with occasional gaps and empties
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 9);
      logic [127:0] c = (sel == 0) ? 128'h0 : rand_cells();
      drive(sel != 1, 16'($urandom), c);
    end
    drive(0, 16'h0, 128'h0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule